// File: doc/BRIEF.md
# Four-Point Linear Convolution Unit

This unit forms the full linear convolution of two sequences of four unsigned 16-bit samples, called `a` and `b`. The result is seven terms. The host presents both sequences in parallel on two packed buses and pulses `start`. The unit captures the operands on that edge and then computes one term per clock.

The terms leave one per cycle on a write-back port that carries a valid strobe, a 3-bit term index and the data. This serial output lets a host register file that accepts one write per cycle store the whole result over seven consecutive cycles. A one-cycle `done` flag follows the last term.

Each term is the unsigned sum of the cross products whose indices add up to the term index, reduced to the low bits of the output width. The number of points, the sample width and the output width are parameters. A parameter also selects how the multipliers are laid out. The defaults give four points, 16-bit samples and a 16-bit result.

Top module: `conv4_unit`

## Requirements
- R1: Sample i of `a` sits on `a_vec[16*i +: 16]` and sample j of `b` on `b_vec[16*j +: 16]`. Both buses are captured on the rising edge at which `start` is high and `busy` is low (an accepted start).
- R2: Term k (k = 0..6) equals the sum of `a_i * b_j` over every pair with i + j = k, treated as unsigned and truncated to its low 16 bits. For example, term 3 is a0*b3 + a1*b2 + a2*b1 + a3*b0.
- R3: Terms leave in index order, from 0 through 6, one per clock. `wb_valid` is high for exactly seven consecutive cycles, and `wb_idx` holds the index of the term on `wb_data`.
- R4: Term k appears on the port in the (k+1)-th cycle after the accepting edge. In the first cycle after that edge, `busy` is high and `wb_valid` is low.
- R5: `busy` stays high from the accepting edge until the edge that places term 6 on the port. While it is high, `start` is ignored and changes on `a_vec` and `b_vec` do not alter the terms being emitted.
- R6: `done` is high for exactly one cycle, the cycle right after term 6 was on the port. In that cycle `wb_valid` is low.
- R7: A synchronous reset clears `busy`, the term counter, `wb_valid` and `done`. Asserting it in the middle of a run aborts the run, and no further terms are emitted.
- R8: A start presented in the cycle that shows term 6 is accepted. Term 0 of the new run appears two cycles later, right after the `done` cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to begin a run; honoured only when idle |
| a_vec | input | 64 | Packed first sequence, sample 0 in the low bits |
| b_vec | input | 64 | Packed second sequence, sample 0 in the low bits |
| busy | output | 1 | A run is in progress; new starts are ignored |
| wb_valid | output | 1 | A term is present on the write-back port |
| wb_idx | output | 3 | Index of the term on `wb_data` |
| wb_data | output | 16 | Truncated term value |
| done | output | 1 | One-cycle pulse after the final term |

## Verification
Relative to the edge that accepts a start, term k is due k+1 cycles later, and the `done` pulse is due eight cycles later. The bench drives its inputs on falling edges. It samples the port on the falling edge of each of those cycles, so every comparison sees the value registered at the preceding rising edge. It also checks that `done` stays low while terms stream out.

The expected terms are computed arithmetically from the captured operands. The bench sweeps zero, saturated, small and pseudo-random sequences. During some runs it holds `start` high and scrambles the operands while busy. It also tests a chained start in the last-term cycle and a reset in the middle of a run.

// File: rtl/conv_pkg.sv
package conv_pkg;

   // Multiplier layout of the term engine.
   //   TERM_SHARED   : one multiplier per `a` sample, the partner chosen by the term index
   //   TERM_PARALLEL : every cross product built at once, the finished term selected after
   typedef enum logic {
      TERM_SHARED   = 1'b0,
      TERM_PARALLEL = 1'b1
   } term_arch_e;

   // Length of the full linear convolution of two n-point sequences.
   function automatic int term_total(input int n);
      return 2 * n - 1;
   endfunction

   // Width of an index able to address every term.
   function automatic int index_width(input int n);
      return (term_total(n) > 1) ? $clog2(term_total(n)) : 1;
   endfunction

endpackage

// File: rtl/conv_operand_bank.sv
module conv_operand_bank #(
   parameter int N = 4,
   parameter int W = 16
) (
   input  logic           clk,
   input  logic           load,
   input  logic [N*W-1:0] a_in,
   input  logic [N*W-1:0] b_in,
   output logic [N*W-1:0] a_q,
   output logic [N*W-1:0] b_q
);

   // Data-only storage: no reset, since the contents are meaningless until a load.
   always_ff @(posedge clk) begin
      if (load) begin
         a_q <= a_in;
         b_q <= b_in;
      end
   end

endmodule

// File: rtl/conv_term_engine.sv
module conv_term_engine
   import conv_pkg::*;
#(
   parameter int         N     = 4,
   parameter int         W     = 16,
   parameter int         OUT_W = 16,
   parameter int         IDX_W = 3,
   parameter term_arch_e ARCH  = TERM_SHARED
) (
   input  logic [N*W-1:0]   a_q,
   input  logic [N*W-1:0]   b_q,
   input  logic [IDX_W-1:0] sel,
   output logic [OUT_W-1:0] term
);

   localparam int TERMS = term_total(N);
   localparam int ACC_W = 2 * W + $clog2(N);

   logic [W-1:0]     a_arr [N];
   logic [W-1:0]     b_arr [N];
   logic [ACC_W-1:0] acc;

   for (genvar i = 0; i < N; i++) begin : g_unpack
      assign a_arr[i] = a_q[i*W +: W];
      assign b_arr[i] = b_q[i*W +: W];
   end

   if (ARCH == TERM_PARALLEL) begin : g_parallel
      // All terms are formed side by side; the index only drives the final mux.
      logic [ACC_W-1:0] sums [TERMS];

      for (genvar k = 0; k < TERMS; k++) begin : g_term
         always_comb begin
            sums[k] = '0;
            for (int i = 0; i < N; i++) begin
               if ((k >= i) && (k - i < N)) begin
                  sums[k] = sums[k] + ACC_W'(a_arr[i]) * ACC_W'(b_arr[k-i]);
               end
            end
         end
      end

      always_comb begin
         acc = '0;
         for (int k = 0; k < TERMS; k++) begin
            if (sel == IDX_W'(k)) acc = sums[k];
         end
      end
   end else begin : g_shared
      // Each a-lane picks the b sample that completes index `sel`, or zero when none does.
      logic [W-1:0] b_pick [N];

      for (genvar i = 0; i < N; i++) begin : g_lane
         always_comb begin
            b_pick[i] = '0;
            for (int j = 0; j < N; j++) begin
               if (sel == IDX_W'(i + j)) b_pick[i] = b_arr[j];
            end
         end
      end

      always_comb begin
         acc = '0;
         for (int i = 0; i < N; i++) begin
            acc = acc + ACC_W'(a_arr[i]) * ACC_W'(b_pick[i]);
         end
      end
   end

   // Wrap-around: keep only the low result bits.
   assign term = acc[OUT_W-1:0];

endmodule

// File: rtl/conv_seq_ctrl.sv
module conv_seq_ctrl #(
   parameter int N     = 4,
   parameter int IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start,
   output logic             accept,
   output logic             busy,
   output logic             emit,
   output logic [IDX_W-1:0] cnt
);

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(2 * N - 2);

   assign accept = start && !busy;
   assign emit   = busy;

   always_ff @(posedge clk) begin
      if (rst) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else if (!busy) begin
         if (start) begin
            busy <= 1'b1;
            cnt  <= '0;
         end
      end else if (cnt == LAST_IDX) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

endmodule

// File: rtl/conv4_unit.sv
module conv4_unit
   import conv_pkg::*;
#(
   parameter int         N      = 4,
   parameter int         DATA_W = 16,
   parameter int         OUT_W  = 16,
   parameter term_arch_e ARCH   = TERM_SHARED,
   localparam int        IDX_W  = index_width(N)
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                start,
   input  logic [N*DATA_W-1:0] a_vec,
   input  logic [N*DATA_W-1:0] b_vec,
   output logic                busy,
   output logic                wb_valid,
   output logic [IDX_W-1:0]    wb_idx,
   output logic [OUT_W-1:0]    wb_data,
   output logic                done
);

   localparam int               ACC_W    = 2 * DATA_W + $clog2(N);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(2 * N - 2);

   if (N < 2) begin : g_bad_points
      $error("conv4_unit: N must be at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("conv4_unit: DATA_W must be positive");
   end
   if ((OUT_W < 1) || (OUT_W > ACC_W)) begin : g_bad_out
      $error("conv4_unit: OUT_W must lie in 1..2*DATA_W+clog2(N)");
   end

   logic                accept;
   logic                emit;
   logic [IDX_W-1:0]    cnt;
   logic [N*DATA_W-1:0] a_q;
   logic [N*DATA_W-1:0] b_q;
   logic [OUT_W-1:0]    term;

   conv_seq_ctrl #(
      .N     (N),
      .IDX_W (IDX_W)
   ) u_ctrl (
      .clk    (clk),
      .rst    (rst),
      .start  (start),
      .accept (accept),
      .busy   (busy),
      .emit   (emit),
      .cnt    (cnt)
   );

   conv_operand_bank #(
      .N (N),
      .W (DATA_W)
   ) u_bank (
      .clk  (clk),
      .load (accept),
      .a_in (a_vec),
      .b_in (b_vec),
      .a_q  (a_q),
      .b_q  (b_q)
   );

   conv_term_engine #(
      .N     (N),
      .W     (DATA_W),
      .OUT_W (OUT_W),
      .IDX_W (IDX_W),
      .ARCH  (ARCH)
   ) u_engine (
      .a_q  (a_q),
      .b_q  (b_q),
      .sel  (cnt),
      .term (term)
   );

   // Registered write-back port: the outputs are stable for the full cycle.
   always_ff @(posedge clk) begin
      if (rst) begin
         wb_valid <= 1'b0;
         wb_idx   <= '0;
         wb_data  <= '0;
         done     <= 1'b0;
      end else begin
         wb_valid <= emit;
         done     <= wb_valid && (wb_idx == LAST_IDX);
         if (emit) begin
            wb_idx  <= cnt;
            wb_data <= term;
         end
      end
   end

endmodule

// File: rtl/conv4_unit_chk.sv
module conv4_unit_chk #(
   parameter int N     = 4,
   parameter int IDX_W = 3
) (
   input logic             clk,
   input logic             rst,
   input logic             start,
   input logic             busy,
   input logic             wb_valid,
   input logic [IDX_W-1:0] wb_idx,
   input logic             done
);

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(2 * N - 2);

   logic rst_q = 1'b0;

   // R7: the edge after a reset leaves everything idle
   always @(posedge clk) begin
      if (rst_q) begin
         p_reset_idle_r7: assert (!busy && !wb_valid && !done)
            else $error("reset did not clear the unit");
      end
      rst_q <= rst;
   end

   // R3: a stream opens at index 0
   p_first_index_r3: assert property (@(posedge clk) disable iff (rst)
      $rose(wb_valid) |-> (wb_idx == '0));

   // R3: indices step by one until the last term
   p_index_step_r3: assert property (@(posedge clk) disable iff (rst)
      (wb_valid && (wb_idx != LAST_IDX)) |=> (wb_valid && (wb_idx == $past(wb_idx) + 1'b1)));

   // R5: a start during a run does not restart the stream
   p_no_restart_r5: assert property (@(posedge clk) disable iff (rst)
      (busy && start && wb_valid) |=> (wb_valid && (wb_idx != '0)));

   // R5: terms before the last are only emitted while busy
   p_busy_covers_r5: assert property (@(posedge clk) disable iff (rst)
      (wb_valid && (wb_idx != LAST_IDX)) |-> busy);

   // R6: done follows the last term, with the port idle
   p_done_after_last_r6: assert property (@(posedge clk) disable iff (rst)
      (wb_valid && (wb_idx == LAST_IDX)) |=> (done && !wb_valid));

   // R6: done lasts a single cycle
   p_done_single_r6: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);

endmodule

bind conv4_unit conv4_unit_chk #(
   .N     (N),
   .IDX_W (IDX_W)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .start    (start),
   .busy     (busy),
   .wb_valid (wb_valid),
   .wb_idx   (wb_idx),
   .done     (done)
);

// File: tb/conv4_unit_bench.sv
module conv4_unit_bench;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        start = 1'b0;
   logic [63:0] a_vec = '0;
   logic [63:0] b_vec = '0;
   logic        busy;
   logic        wb_valid;
   logic [2:0]  wb_idx;
   logic [15:0] wb_data;
   logic        done;

   int  n_checks = 0;
   int  n_fails  = 0;
   bit  finished = 1'b0;
   logic [31:0] seed = 32'h1234_5678;

   always #5 clk = ~clk;

   conv4_unit u_conv4_unit (
      .clk      (clk),
      .rst      (rst),
      .start    (start),
      .a_vec    (a_vec),
      .b_vec    (b_vec),
      .busy     (busy),
      .wb_valid (wb_valid),
      .wb_idx   (wb_idx),
      .wb_data  (wb_data),
      .done     (done)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // R2: sum of a_i*b_j over i+j=k, truncated to 16 bits
   function automatic logic [15:0] exp_term(input logic [63:0] a, input logic [63:0] b, input int k);
      logic [33:0] s = '0;
      for (int i = 0; i < 4; i++)
         for (int j = 0; j < 4; j++)
            if (i + j == k) s = s + 34'(a[16*i +: 16]) * 34'(b[16*j +: 16]);
      return s[15:0];
   endfunction

   function automatic logic [31:0] step(input logic [31:0] s);
      s = s ^ (s << 13);
      s = s ^ (s >> 17);
      s = s ^ (s << 5);
      return s;
   endfunction

   function automatic logic [63:0] rnd64();
      seed = step(seed);
      rnd64[31:0] = seed;
      seed = step(seed);
      rnd64[63:32] = seed;
   endfunction

   // Call at a falling edge; the next rising edge accepts.
   task automatic kick(input logic [63:0] a, input logic [63:0] b);
      a_vec = a;
      b_vec = b;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, "R4 busy after accept", 32'(busy), 32'd1);
      chk(wb_valid == 1'b0, "R4 no term in first cycle", 32'(wb_valid), 32'd0);
   endtask

   // Entered in the first cycle after the accepting edge.
   task automatic stream(input logic [63:0] a, input logic [63:0] b, input bit disturb,
                         input bit chain, input logic [63:0] ca, input logic [63:0] cb);
      if (disturb) begin
         start = 1'b1;                       // R5: ignored while busy
         a_vec = ~a;
         b_vec = {b[15:0], b[63:16]};
      end
      for (int k = 0; k < 7; k++) begin
         @(negedge clk);
         chk(wb_valid == 1'b1, "R3 valid during stream", 32'(wb_valid), 32'd1);
         chk(wb_idx == 3'(k), "R3 index order", 32'(wb_idx), 32'(k));
         chk(wb_data == exp_term(a, b, k), disturb ? "R5 term unaffected" : "R2 term value",
             32'(wb_data), 32'(exp_term(a, b, k)));
         chk(done == 1'b0, "R6 done low while streaming", 32'(done), 32'd0);
         if (k < 6) chk(busy == 1'b1, "R5 busy during run", 32'(busy), 32'd1);
         if (disturb && k < 5) begin
            a_vec = rnd64();
            b_vec = rnd64();
         end else begin
            start = 1'b0;
         end
         if (k == 6 && chain) begin
            a_vec = ca;                      // R8: start in the last-term cycle
            b_vec = cb;
            start = 1'b1;
         end
      end
      @(negedge clk);
      start = 1'b0;
      chk(done == 1'b1, "R6 done after last", 32'(done), 32'd1);
      chk(wb_valid == 1'b0, "R6 port idle with done", 32'(wb_valid), 32'd0);
      if (chain) begin
         chk(busy == 1'b1, "R8 chained start accepted", 32'(busy), 32'd1);
      end else begin
         @(negedge clk);
         chk(done == 1'b0, "R6 done single cycle", 32'(done), 32'd0);
         chk(busy == 1'b0, "R5 idle after run", 32'(busy), 32'd0);
      end
   endtask

   initial begin
      logic [63:0] a, b, a2, b2;
      repeat (3) @(negedge clk);
      chk(busy == 1'b0, "R7 reset busy", 32'(busy), 32'd0);
      chk(wb_valid == 1'b0, "R7 reset valid", 32'(wb_valid), 32'd0);
      chk(done == 1'b0, "R7 reset done", 32'(done), 32'd0);
      rst = 1'b0;
      @(negedge clk);

      for (int p = 0; p < 40; p++) begin
         case (p)
            0:       begin a = '0;                          b = rnd64();                     end
            1:       begin a = {4{16'hFFFF}};               b = {4{16'hFFFF}};               end
            2:       begin a = {16'd4, 16'd3, 16'd2, 16'd1}; b = {16'd8, 16'd7, 16'd6, 16'd5}; end
            3:       begin a = {48'd0, 16'd1};              b = rnd64();                     end
            4:       begin a = rnd64();                     b = {16'd1, 48'd0};              end
            default: begin a = rnd64();                     b = rnd64();                     end
         endcase
         kick(a, b);                          // R1: packed sample positions
         stream(a, b, (p % 3) == 1, 1'b0, '0, '0);
      end

      // R8: back-to-back runs
      a = rnd64(); b = rnd64(); a2 = rnd64(); b2 = rnd64();
      kick(a, b);
      stream(a, b, 1'b0, 1'b1, a2, b2);
      stream(a2, b2, 1'b0, 1'b0, '0, '0);

      // R7: reset in the middle of a run
      a = rnd64(); b = rnd64();
      kick(a, b);
      repeat (3) @(negedge clk);
      chk(wb_idx == 3'd2, "R7 run reached term 2", 32'(wb_idx), 32'd2);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk(wb_valid == 1'b0, "R7 abort clears valid", 32'(wb_valid), 32'd0);
      chk(busy == 1'b0, "R7 abort clears busy", 32'(busy), 32'd0);
      for (int c = 0; c < 4; c++) begin
         @(negedge clk);
         chk(wb_valid == 1'b0, "R7 no terms after abort", 32'(wb_valid), 32'd0);
         chk(done == 1'b0, "R7 no done after abort", 32'(done), 32'd0);
      end
      kick(a, b);
      stream(a, b, 1'b0, 1'b0, '0, '0);

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

endmodule